// File: doc/BRIEF.md
# ST-BUS Clock and Frame Pulse Generator

This block derives a complete set of ST-BUS timing signals from a single 32.768 MHz master clock. A free-running frame counter is shared by every output and wraps once every 4096 master cycles, which gives the 125 µs (8 kHz) frame. From that counter the block forms four binary-divided bit clocks and a family of frame-start strobes. Each strobe has its own width and polarity, and all of them begin in the same master cycle.

Downstream serial-bus logic uses the bit clock that matches its data rate and the frame strobe that its interface expects. Because every output comes from the same count, a consumer can combine any bit clock with any strobe and never sees a phase offset between them. All outputs are registered. A synchronous active-high reset puts every output into its idle level. The first frame starts in the first cycle after reset is released.

Top module: `stbus_timing_gen`

## Requirements
- R1: While `rst` is sampled high, every bit clock and every active-high strobe (`fp_quad`, `rx_sync`, `tx_sync`, `frame_mark`) is low, and every active-low strobe (`fp_narrow_n`, `fp_double_n`, `fp_octal_n`) is high.
- R2: Every strobe repeats with a period of exactly 4096 master cycles.
- R3: `fp_narrow_n` is low for exactly 1 master cycle per frame.
- R4: `fp_double_n` is low for exactly 2 consecutive master cycles per frame.
- R5: `fp_quad` is high for exactly 4 consecutive master cycles per frame.
- R6: `fp_octal_n` is low for exactly 8 consecutive master cycles per frame.
- R7: `rx_sync` and `tx_sync` are equal in every cycle, and each is high for exactly 16 consecutive master cycles per frame.
- R8: Every strobe enters its active level in the cycle in which `frame_mark` is high, and `frame_mark` is high for one cycle per frame.
- R9: `bclk_16m`, `bclk_8m`, `bclk_4m` and `bclk_2m` have periods of 2, 4, 8 and 16 master cycles, with a 50% duty cycle. Each clock is high during the first half of its period.
- R10: Every bit clock goes from low to high in the `frame_mark` cycle.
- R11: `frame_mark` is high in the first master cycle after the first rising edge at which `rst` is sampled low, including after a reset in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_16m | output | 1 | 16.384 MHz bit clock |
| bclk_8m | output | 1 | 8.192 MHz bit clock |
| bclk_4m | output | 1 | 4.096 MHz bit clock |
| bclk_2m | output | 1 | 2.048 MHz bit clock |
| fp_narrow_n | output | 1 | Active-low frame strobe, 1 cycle wide |
| fp_double_n | output | 1 | Active-low frame strobe, 2 cycles wide |
| fp_quad | output | 1 | Active-high frame strobe, 4 cycles wide |
| fp_octal_n | output | 1 | Active-low frame strobe, 8 cycles wide |
| rx_sync | output | 1 | Active-high receive sync strobe, 16 cycles wide |
| tx_sync | output | 1 | Active-high transmit sync strobe, 16 cycles wide |
| frame_mark | output | 1 | Active-high frame-start marker, 1 cycle wide |

## Verification
The properties assume that `rst` only changes between master clock edges and that it is asserted from the first edge onward, so the output registers hold defined idle values before any edge is compared with its predecessor. The bench changes `rst` only on the falling clock edge. It holds reset from time zero, and later it asserts reset again partway through a frame. This second reset checks that the frame restarts from the release edge. The period property counts cycles between markers and clears its count on reset, so a shortened frame interrupted by reset never counts as a violation.

// File: rtl/stbus_pkg.sv
package stbus_pkg;

  // Frame timebase: 2**FRAME_BITS master cycles per 8 kHz frame.
  localparam int FRAME_BITS = 12;
  localparam int FRAME_LEN  = 1 << FRAME_BITS;

  // Number of binary-divided bit clocks.
  localparam int NUM_DIV = 4;

  // Strobe slots, in the order used by the shaper generate loop.
  typedef enum int {
    SLOT_NARROW = 0,
    SLOT_DOUBLE = 1,
    SLOT_QUAD   = 2,
    SLOT_OCTAL  = 3,
    SLOT_RX     = 4,
    SLOT_TX     = 5,
    SLOT_MARK   = 6
  } fp_slot_e;

  localparam int NUM_FP = 7;

  // Polarity per slot: 1 means active low.
  function automatic bit slot_active_low(int slot);
    case (slot)
      SLOT_NARROW, SLOT_DOUBLE, SLOT_OCTAL: return 1'b1;
      default:                              return 1'b0;
    endcase
  endfunction

  // Width per slot, selected from the parameter values passed in.
  function automatic int slot_width(int slot, int w_narrow, int w_double,
                                    int w_quad, int w_octal, int w_sync);
    case (slot)
      SLOT_NARROW: return w_narrow;
      SLOT_DOUBLE: return w_double;
      SLOT_QUAD:   return w_quad;
      SLOT_OCTAL:  return w_octal;
      SLOT_RX:     return w_sync;
      SLOT_TX:     return w_sync;
      default:     return 1;
    endcase
  endfunction

endpackage

// File: rtl/stbus_frame_ctr.sv
module stbus_frame_ctr #(
  parameter int CNT_W = stbus_pkg::FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_nxt
);

  logic [CNT_W-1:0] cnt_q;

  // The counter parks at its top value during reset, so the first edge
  // after release moves it to zero and starts a frame.
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '1;
    else     cnt_q <= cnt_nxt;
  end

  assign cnt_nxt = cnt_q + 1'b1;

endmodule

// File: rtl/stbus_clk_div.sv
module stbus_clk_div #(
  parameter int NUM_DIV = stbus_pkg::NUM_DIV
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DIV-1:0] cnt_low_nxt,
  output logic [NUM_DIV-1:0] bclk
);

  // Clock i is high while counter bit i is zero, so it rises at count zero.
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    always_ff @(posedge clk) begin
      if (rst) bclk[i] <= 1'b0;
      else     bclk[i] <= ~cnt_low_nxt[i];
    end
  end

endmodule

// File: rtl/stbus_pulse_shaper.sv
module stbus_pulse_shaper #(
  parameter int CNT_W      = stbus_pkg::FRAME_BITS,
  parameter int WIDTH      = 1,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             pulse_o
);

  localparam logic [CNT_W:0] LIMIT = (CNT_W + 1)'(WIDTH);
  localparam logic           IDLE  = ACTIVE_LOW;

  logic in_window;

  // Active while the upcoming count falls in [0, WIDTH).
  assign in_window = ({1'b0, cnt_nxt} < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= IDLE;
    else     pulse_o <= in_window ^ IDLE;
  end

endmodule

// File: rtl/stbus_timing_gen.sv
module stbus_timing_gen #(
  parameter int CNT_W    = stbus_pkg::FRAME_BITS,
  parameter int W_NARROW = 1,
  parameter int W_DOUBLE = 2,
  parameter int W_QUAD   = 4,
  parameter int W_OCTAL  = 8,
  parameter int W_SYNC   = 16
) (
  input  logic clk,
  input  logic rst,
  output logic bclk_16m,
  output logic bclk_8m,
  output logic bclk_4m,
  output logic bclk_2m,
  output logic fp_narrow_n,
  output logic fp_double_n,
  output logic fp_quad,
  output logic fp_octal_n,
  output logic rx_sync,
  output logic tx_sync,
  output logic frame_mark
);

  import stbus_pkg::*;

  localparam int DIVS = NUM_DIV;

  logic [CNT_W-1:0]  cnt_nxt;
  logic [DIVS-1:0]   bclk_vec;
  logic [NUM_FP-1:0] fp_vec;

  stbus_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .cnt_nxt (cnt_nxt)
  );

  stbus_clk_div #(.NUM_DIV(DIVS)) u_div (
    .clk         (clk),
    .rst         (rst),
    .cnt_low_nxt (cnt_nxt[DIVS-1:0]),
    .bclk        (bclk_vec)
  );

  for (genvar s = 0; s < NUM_FP; s++) begin : g_fp
    stbus_pulse_shaper #(
      .CNT_W      (CNT_W),
      .WIDTH      (slot_width(s, W_NARROW, W_DOUBLE, W_QUAD, W_OCTAL, W_SYNC)),
      .ACTIVE_LOW (slot_active_low(s))
    ) u_shp (
      .clk     (clk),
      .rst     (rst),
      .cnt_nxt (cnt_nxt),
      .pulse_o (fp_vec[s])
    );
  end

  assign bclk_16m    = bclk_vec[0];
  assign bclk_8m     = bclk_vec[1];
  assign bclk_4m     = bclk_vec[2];
  assign bclk_2m     = bclk_vec[3];
  assign fp_narrow_n = fp_vec[SLOT_NARROW];
  assign fp_double_n = fp_vec[SLOT_DOUBLE];
  assign fp_quad     = fp_vec[SLOT_QUAD];
  assign fp_octal_n  = fp_vec[SLOT_OCTAL];
  assign rx_sync     = fp_vec[SLOT_RX];
  assign tx_sync     = fp_vec[SLOT_TX];
  assign frame_mark  = fp_vec[SLOT_MARK];

endmodule

// File: rtl/stbus_timing_chk.sv
module stbus_timing_chk #(
  parameter int PERIOD = stbus_pkg::FRAME_LEN
) (
  input logic clk,
  input logic rst,
  input logic bclk_16m,
  input logic bclk_8m,
  input logic bclk_4m,
  input logic bclk_2m,
  input logic fp_narrow_n,
  input logic fp_double_n,
  input logic fp_quad,
  input logic fp_octal_n,
  input logic rx_sync,
  input logic tx_sync,
  input logic frame_mark
);

  logic past_valid = 1'b0;
  logic seen_mark;
  int   gap;

  always_ff @(posedge clk) past_valid <= 1'b1;

  // Cycles since the previous marker; cleared by reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap       <= 0;
      seen_mark <= 1'b0;
    end else if (frame_mark) begin
      gap       <= 0;
      seen_mark <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    (past_valid && $past(rst)) |->
      (!bclk_16m && !bclk_8m && !bclk_4m && !bclk_2m && fp_narrow_n &&
       fp_double_n && !fp_quad && fp_octal_n && !rx_sync && !tx_sync &&
       !frame_mark));

  p_period_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_mark && seen_mark) |-> (gap == PERIOD - 1));

  p_narrow_one_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(fp_narrow_n) |=> fp_narrow_n);

  p_double_two_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(fp_double_n) |=> !fp_double_n ##1 fp_double_n);

  p_quad_four_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fp_quad) |=> fp_quad ##1 fp_quad ##1 fp_quad ##1 !fp_quad);

  p_sync_match_r7: assert property (@(posedge clk) disable iff (rst)
    rx_sync == tx_sync);

  p_edges_align_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_mark) |->
      (!fp_narrow_n && !fp_double_n && fp_quad && !fp_octal_n && rx_sync &&
       $fell(fp_narrow_n) && $fell(fp_octal_n) && $rose(rx_sync)));

  p_fast_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(rst)) |-> (bclk_16m != $past(bclk_16m)));

  p_clk_rise_r10: assert property (@(posedge clk) disable iff (rst)
    frame_mark |->
      ($rose(bclk_16m) && $rose(bclk_8m) && $rose(bclk_4m) && $rose(bclk_2m)));

  p_restart_r11: assert property (@(posedge clk)
    (past_valid && $fell(rst)) |=> frame_mark);

endmodule

bind stbus_timing_gen stbus_timing_chk u_chk (.*);

// File: tb/stbus_timing_gen_bench.sv
module stbus_timing_gen_bench;

  localparam int CLK_PERIOD = 30;
  localparam int FRAME      = 4096;
  localparam int MAX_CYC    = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk_16m, bclk_8m, bclk_4m, bclk_2m;
  logic fp_narrow_n, fp_double_n, fp_quad, fp_octal_n;
  logic rx_sync, tx_sync, frame_mark;

  int checks = 0;
  int errors = 0;
  int ph     = -1;   // model frame phase; -1 means held in reset
  bit run    = 1'b0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stbus_timing_gen u_stbus_timing_gen (
    .clk (clk), .rst (rst),
    .bclk_16m (bclk_16m), .bclk_8m (bclk_8m),
    .bclk_4m (bclk_4m), .bclk_2m (bclk_2m),
    .fp_narrow_n (fp_narrow_n), .fp_double_n (fp_double_n),
    .fp_quad (fp_quad), .fp_octal_n (fp_octal_n),
    .rx_sync (rx_sync), .tx_sync (tx_sync), .frame_mark (frame_mark)
  );

  // Reference phase: advances once per master cycle, restarts after reset.
  always @(posedge clk) begin
    if (rst) ph <= -1;
    else     ph <= (ph + 1) % FRAME;
  end

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at phase %0d: actual %b expected %b", what, ph, act, exp);
    end
  endtask

  function automatic logic win(int p, int w, bit low);
    logic on = (p >= 0) && (p < w);
    return low ? !on : on;
  endfunction

  function automatic logic clk_model(int p, int half);
    if (p < 0) return 1'b0;
    return (p % (2 * half)) < half;
  endfunction

  always @(negedge clk) begin
    if (run) begin
      chk(fp_narrow_n, win(ph, 1, 1'b1),  "R3 R8 R2 R1 fp_narrow_n");
      chk(fp_double_n, win(ph, 2, 1'b1),  "R4 R8 R2 R1 fp_double_n");
      chk(fp_quad,     win(ph, 4, 1'b0),  "R5 R8 R2 R1 fp_quad");
      chk(fp_octal_n,  win(ph, 8, 1'b1),  "R6 R8 R2 R1 fp_octal_n");
      chk(rx_sync,     win(ph, 16, 1'b0), "R7 R8 R2 R1 rx_sync");
      chk(tx_sync,     win(ph, 16, 1'b0), "R7 R8 R2 R1 tx_sync");
      chk(frame_mark,  win(ph, 1, 1'b0),  "R8 R11 R2 R1 frame_mark");
      chk(bclk_16m, clk_model(ph, 1), "R9 R10 R1 bclk_16m");
      chk(bclk_8m,  clk_model(ph, 2), "R9 R10 R1 bclk_8m");
      chk(bclk_4m,  clk_model(ph, 4), "R9 R10 R1 bclk_4m");
      chk(bclk_2m,  clk_model(ph, 8), "R9 R10 R1 bclk_2m");
    end
  end

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    run = 1'b1;
    wait_cycles(5);            // R1: idle levels under reset
    rst = 1'b0;                // R11: first frame after release
    wait_cycles(3 * FRAME + 777);
    rst = 1'b1;                // reset in the middle of a frame
    wait_cycles(3);
    rst = 1'b0;                // R11: restart from the release edge
    wait_cycles(2 * FRAME + 50);
    run  = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule